// File: doc/BRIEF.md
# Chip-Select Register and Activation Unit

This block holds the five control registers that configure the external chip selects of a 20-bit address space. Software writes them through a simple internal register port: a write strobe, a 3-bit register index and a 16-bit data word. Each write updates the register on the next rising clock edge. The unit records which registers have ever been written. From those records it decides when each group of external selects may assert. The upper-memory select is the only one usable straight out of reset.

On every cycle the unit decodes the current address against the programmed regions. It drives at most one select, chosen by a fixed priority. It also reports the ready mode and the wait-state count of the winning region, so that the bus sequencer can time the access. A fixed internal window for the on-chip control block has the highest priority. That window blocks every external select and always reports zero wait states with ready ignored.

Register indices: 0 upper, 1 lower, 2 mid-range, 3 peripheral base, 4 shared mid/peripheral. Indices 5 to 7 are unused. Address decode and outputs are combinational from the registered state and the `addr` input.

Top module: `csel_unit`

## Requirements
- R1: After reset the upper register holds 16'hF003: mask 8'hF0, ready required, 3 wait states. Any address with addr[19:16]==4'hF that is outside the internal window asserts `cs_upper`, with `sel_wait`=3 and `sel_rdy_ignore`=0, and no write is needed first.
- R2: `cs_lower` cannot assert until the lower register (index 1) has been written at least once.
- R3: The `cs_mid` selects cannot assert until both the mid-range register (index 2) and the shared register (index 4) have been written, in either order.
- R4: The `cs_per` selects cannot assert until both the peripheral base register (index 3) and the shared register (index 4) have been written, in either order.
- R5: Write-seen state is sticky until reset. A write to indices 5 to 7 changes no register and no output.
- R6: Bit 2 of a region's timing register is its ready mode: 1 means external ready is ignored, 0 means it is required. It appears on `sel_rdy_ignore` when that region wins.
- R7: The wait count is bits [1:0] for the upper, lower and mid regions (0 to 3). For the peripheral region it is {bit4, bit3, bit1, bit0} of the peripheral register (0 to 15). The mid selects take their timing from the mid-range register.
- R8: Decode uses h=addr[19:12]. Upper matches when (h & U)==U, with U = upper register bits [15:8]. Lower matches when (h & L)==0, with L = lower register bits [15:8]. Mid matches when (h & M)==(B & M), with B = mid register bits [15:8] and M = shared register bits [15:8]; the select index is addr[11:10]. Peripheral matches when h equals peripheral register bits [15:8] and addr[11:9]==0; the select index is addr[8:7].
- R9: Priority is internal window, then upper, then lower, then mid, then peripheral. Only the winner asserts, so at most one of `pcb_hit`, `cs_upper`, `cs_lower`, `cs_mid`, `cs_per` is high.
- R10: When addr[19:8] equals PCB_BASE (default 12'hFFF), `pcb_hit` is high, every external select is low, `sel_wait`=0 and `sel_rdy_ignore`=1.
- R11: When no region matches, all selects are low, `sel_wait`=0 and `sel_rdy_ignore`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register index |
| wr_data | input | 16 | Register write data |
| addr | input | 20 | Address to decode |
| pcb_hit | output | 1 | Internal control-block window hit |
| cs_upper | output | 1 | Upper-memory select |
| cs_lower | output | 1 | Lower-memory select |
| cs_mid | output | 4 | Mid-range selects, one-hot |
| cs_per | output | 4 | Peripheral selects, one-hot |
| sel_rdy_ignore | output | 1 | Ready mode of the selected region |
| sel_wait | output | 4 | Wait states of the selected region |

## Verification
The assertions assume that `wr_sel` and `wr_en` are never unknown once reset is released. They also assume that a register write changes the decode only from the following cycle on. The checks on the gated groups then rely only on the write history and not on the address.

The bench drives every input from the falling edge, so each write is settled well before the rising edge that captures it. Its random addresses are drawn near the programmed bases and the internal window, so that overlaps and priority cases occur often. Reset is applied twice, so that the shared register can be written both before and after its partner.

// File: rtl/csel_unit.sv
module csel_unit #(
  parameter logic [11:0] PCB_BASE  = 12'hFFF,
  parameter logic [15:0] UPPER_RST = 16'hF003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [15:0] wr_data,
  input  logic [19:0] addr,
  output logic        pcb_hit,
  output logic        cs_upper,
  output logic        cs_lower,
  output logic [3:0]  cs_mid,
  output logic [3:0]  cs_per,
  output logic        sel_rdy_ignore,
  output logic [3:0]  sel_wait
);

  logic [15:0] r_up, r_lo, r_mid, r_per, r_shr;
  logic        seen_lo, seen_mid, seen_per, seen_shr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_up     <= UPPER_RST;
      r_lo     <= '0;
      r_mid    <= '0;
      r_per    <= '0;
      r_shr    <= '0;
      seen_lo  <= 1'b0;
      seen_mid <= 1'b0;
      seen_per <= 1'b0;
      seen_shr <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: r_up <= wr_data;
        3'd1: begin r_lo  <= wr_data; seen_lo  <= 1'b1; end
        3'd2: begin r_mid <= wr_data; seen_mid <= 1'b1; end
        3'd3: begin r_per <= wr_data; seen_per <= 1'b1; end
        3'd4: begin r_shr <= wr_data; seen_shr <= 1'b1; end
        default: ;
      endcase
    end
  end

  wire [7:0] hi = addr[19:12];
  wire hit_pcb = addr[19:8] == PCB_BASE;
  wire hit_up  = (hi & r_up[15:8]) == r_up[15:8];
  wire hit_lo  = seen_lo && ((hi & r_lo[15:8]) == 8'h00);
  wire hit_mid = seen_mid && seen_shr && ((hi & r_shr[15:8]) == (r_mid[15:8] & r_shr[15:8]));
  wire hit_per = seen_per && seen_shr && (hi == r_per[15:8]) && (addr[11:9] == 3'b000);

  always_comb begin
    pcb_hit        = 1'b0;
    cs_upper       = 1'b0;
    cs_lower       = 1'b0;
    cs_mid         = '0;
    cs_per         = '0;
    sel_rdy_ignore = 1'b1;
    sel_wait       = '0;
    if (hit_pcb) begin
      pcb_hit = 1'b1;
    end else if (hit_up) begin
      cs_upper       = 1'b1;
      sel_rdy_ignore = r_up[2];
      sel_wait       = {2'b00, r_up[1:0]};
    end else if (hit_lo) begin
      cs_lower       = 1'b1;
      sel_rdy_ignore = r_lo[2];
      sel_wait       = {2'b00, r_lo[1:0]};
    end else if (hit_mid) begin
      cs_mid[addr[11:10]] = 1'b1;
      sel_rdy_ignore      = r_mid[2];
      sel_wait            = {2'b00, r_mid[1:0]};
    end else if (hit_per) begin
      cs_per[addr[8:7]] = 1'b1;
      sel_rdy_ignore    = r_per[2];
      sel_wait          = {r_per[4], r_per[3], r_per[1:0]};
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pcb_hit, cs_upper, cs_lower, (|cs_mid), (|cs_per)}) && $onehot0(cs_mid) && $onehot0(cs_per)); // R9
  AST_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) seen_lo |=> seen_lo); // R5
  AST_SHR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) seen_shr |=> seen_shr); // R5
  AST_LO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seen_lo) |-> $past(wr_en && wr_sel == 3'd1)); // R2
  AST_MID_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs_mid) |-> (seen_mid && seen_shr)); // R3
  AST_PER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs_per) |-> (seen_per && seen_shr)); // R4
  AST_PCB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pcb_hit |-> (sel_wait == 4'd0 && sel_rdy_ignore)); // R10
  AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(pcb_hit || cs_upper || cs_lower || (|cs_mid) || (|cs_per)) |-> (sel_wait == 4'd0 && sel_rdy_ignore)); // R11
  AST_SHORT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_upper || cs_lower || (|cs_mid)) |-> (sel_wait[3:2] == 2'b00)); // R7

endmodule

// File: tb/tb_csel_unit.sv
module tb_csel_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [19:0] addr = '0;
  logic        pcb_hit, cs_upper, cs_lower, sel_rdy_ignore;
  logic [3:0]  cs_mid, cs_per, sel_wait;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] m_up, m_lo, m_mid, m_per, m_shr;
  bit s_lo, s_mid, s_per, s_shr;

  always #4 clk = ~clk;

  csel_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .addr(addr), .pcb_hit(pcb_hit), .cs_upper(cs_upper), .cs_lower(cs_lower),
    .cs_mid(cs_mid), .cs_per(cs_per), .sel_rdy_ignore(sel_rdy_ignore), .sel_wait(sel_wait)
  );

  // packed view: {pcb, up, lo, mid[3:0], per[3:0], rdy_ignore, wait[3:0]}
  function automatic logic [15:0] model(input logic [19:0] a);
    logic [7:0] h;
    h = a[19:12];
    if (a[19:8] == 12'hFFF) return {1'b1, 10'b0, 1'b1, 4'd0};
    if ((h & m_up[15:8]) == m_up[15:8]) return {1'b0, 1'b1, 9'b0, m_up[2], 2'b00, m_up[1:0]};
    if (s_lo && (h & m_lo[15:8]) == 8'h00) return {2'b00, 1'b1, 8'b0, m_lo[2], 2'b00, m_lo[1:0]};
    if (s_mid && s_shr && (h & m_shr[15:8]) == (m_mid[15:8] & m_shr[15:8]))
      return {3'b000, 4'b0001 << a[11:10], 4'b0, m_mid[2], 2'b00, m_mid[1:0]};
    if (s_per && s_shr && h == m_per[15:8] && a[11:9] == 3'b000)
      return {7'b0, 4'b0001 << a[8:7], m_per[2], m_per[4], m_per[3], m_per[1:0]};
    return {11'b0, 1'b1, 4'd0};
  endfunction

  function automatic string tag_of(input logic [15:0] e);
    if (e[15]) return "R10";
    if (e[14]) return "R1";
    if (e[13]) return "R2";
    if (|e[12:9]) return "R3";
    if (|e[8:5]) return "R4";
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    logic [15:0] act;
    act = {pcb_hit, cs_upper, cs_lower, cs_mid, cs_per, sel_rdy_ignore, sel_wait};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%05h actual=%04h expected=%04h", tag, addr, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    m_up = 16'hF003; m_lo = '0; m_mid = '0; m_per = '0; m_shr = '0;
    s_lo = 0; s_mid = 0; s_per = 0; s_shr = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle: drive at negedge, check decode of current state, then capture write
  task automatic step(input bit we, input logic [2:0] sel, input logic [15:0] d,
                      input logic [19:0] a, input string tag);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; addr = a;
    #1;
    check(tag.len() ? tag : tag_of(model(a)), model(a));
    @(posedge clk);
    if (we) begin
      case (sel)
        3'd0: m_up = d;
        3'd1: begin m_lo = d; s_lo = 1; end
        3'd2: begin m_mid = d; s_mid = 1; end
        3'd3: begin m_per = d; s_per = 1; end
        3'd4: begin m_shr = d; s_shr = 1; end
        default: ;
      endcase
    end
  endtask

  task automatic probe(input logic [19:0] a, input string tag);
    step(1'b0, 3'd0, 16'h0, a, tag);
  endtask

  function automatic logic [19:0] pick_addr();
    logic [19:0] r;
    r = 20'($urandom);
    case ($urandom % 6)
      0: return r;
      1: return {m_mid[15:8], r[11:0]};
      2: return {m_per[15:8], 3'b000, r[8:0]};
      3: return {12'hFFF, r[7:0]};
      4: return {4'hF, r[15:0]};
      default: return {4'h0, r[15:0]};
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    probe(20'hF1234, "R1");
    probe(20'h00000, "R2");
    step(1'b1, 3'd2, 16'h2005, 20'h20400, "R3");
    probe(20'h20400, "R3");
    step(1'b1, 3'd4, 16'hF000, 20'h20400, "R3");
    probe(20'h20400, "R8");
    probe(20'h20C00, "R6");
    step(1'b1, 3'd1, 16'hC006, 20'h10000, "R2");
    probe(20'h20400, "R9");
    probe(20'h10000, "R7");
    step(1'b1, 3'd3, 16'h801B, 20'h80180, "R4");
    probe(20'h80180, "R7");
    probe(20'h80200, "R8");
    probe(20'h80000, "R4");
    probe(20'hFFF10, "R10");
    probe(20'hFFE10, "R9");
    step(1'b1, 3'd5, 16'hFFFF, 20'h10000, "R5");
    step(1'b1, 3'd7, 16'h0000, 20'h10000, "R5");
    probe(20'h10000, "R5");
    probe(20'h80100, "R5");
    probe(20'h90000, "R11");

    do_reset();
    probe(20'hFABCD, "R1");
    step(1'b1, 3'd3, 16'h4004, 20'h40000, "R4");
    probe(20'h40000, "R4");
    step(1'b1, 3'd4, 16'hFF00, 20'h40000, "R4");
    probe(20'h40080, "R4");
    probe(20'h40000, "R6");

    for (int i = 0; i < 4000; i++) begin
      bit we;
      we = ($urandom % 4) == 0;
      step(we, 3'($urandom), 16'($urandom), pick_addr(), "");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule